// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block decides when an oversampled converter runs. It watches an external start pin, a control-register write carrying self-clearing start and stop command bits, and a notification of writes to other configuration registers. From these it walks a small state machine through an optional start delay and a programmable number of modulator clocks per conversion. Each finished conversion gives a one-cycle done pulse, and it raises a new-data status bit whose inverse drives an active-low data-ready pin. One clock cycle of `clk` is one modulator clock.

A programmed 2-bit mode selects how conversions run. In free-running mode a start runs conversions back to back until a stop. In single mode a start runs exactly one conversion. In pin-follow mode the level of the start pin gates conversions and the command bits are ignored. The fourth code is reserved and starts nothing. Writing a fixed key pattern to the control register asks for a device reset. The block sends that request out and returns the sequencer to idle.

States: `S_IDLE` (no conversion), `S_DELAY` (counting the start delay), `S_CONV` (counting a conversion). Transitions: IDLE→DELAY or IDLE→CONV on a start event (CONV when the delay code is 0). DELAY→CONV when the delay count is reached. CONV→CONV at the end of a conversion when running continuously. CONV→IDLE at the end of a conversion in single mode or with a stop pending. Any busy state→DELAY/CONV on a restart. Any state→IDLE on a pin-follow halt or a reset key.

Top module: `conv_sequencer`

## Requirements
- R1: After reset `conv_active`, `conv_done`, `data_new` and `dev_rst_req` are 0 and `drdy_n` is 1.
- R2: The `mode` encoding is 00 free-running, 01 single, 10 pin-follow and 11 reserved. In mode 11 neither the start command bit nor a start pin edge begins a conversion.
- R3: A control write with bit 1 set and bit 0 clear (the start bit) begins conversions. With delay code 0, `conv_active` is 1 in the cycle after the write's clock edge.
- R4: A conversion lasts `conv_len` clocks. `conv_done` is high for the single cycle that follows the conversion's last clock edge. With the start on edge E and delay D, the first pulse follows edge E+D+`conv_len`, and in free-running mode later pulses follow every `conv_len` edges.
- R5: A control write with bit 0 set and bit 1 clear (the stop bit) does not cut the running conversion short. That conversion still produces its done pulse, and then the sequencer goes idle.
- R6: A control write with both bits 1 and 0 set does nothing in any mode. In mode 10 the start and stop bits do nothing.
- R7: In single mode exactly one conversion runs per start. `data_new` then stays 1, even when `data_rd` pulses, until the next start event clears it.
- R8: A start event while a delay or conversion is in progress aborts it with no done pulse and begins again from the delay.
- R9: `dly_code` values 0 to 7 insert 0, 4, 8, 16, 32, 128, 512 and 1024 clocks between the start event and the first conversion clock.
- R10: A configuration write (`cfg_wr`) to an address above 04h restarts as in R8 while the sequencer is busy. Addresses 04h and below, and any write while idle, have no effect.
- R11: In mode 10 a rising start pin starts or restarts conversions. A low pin halts at once, with no done pulse for the aborted conversion.
- R12: In modes 00 and 01 a rising edge of `start_pin` acts exactly like the start command bit.
- R13: `data_new` becomes 1 with each done pulse and `drdy_n` is always its inverse. Outside single mode a `data_rd` pulse clears it.
- R14: A control write of 58h (key 010110b in bits 7:2, both command bits 0) pulses `dev_rst_req` for one cycle after its edge. It also returns the sequencer to idle and clears `data_new` on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin | input | 1 | External start/gate pin, synchronous to `clk` |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 1 start, bit 0 stop, bits 7:2 reset key |
| cfg_wr | input | 1 | Strobe for a write to some other register |
| cfg_addr | input | ADDR_W | Address of that register write |
| mode | input | 2 | Control mode (see R2) |
| dly_code | input | 3 | Start delay code (see R9) |
| conv_len | input | LEN_W | Modulator clocks per conversion |
| data_rd | input | 1 | Conversion data has been read |
| conv_active | output | 1 | A conversion is being counted |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |
| data_new | output | 1 | Status bit: output data are new |
| drdy_n | output | 1 | Active-low data-ready pin, inverse of `data_new` |
| dev_rst_req | output | 1 | One-cycle device reset request |

## Verification
Every result is due a fixed number of edges after the edge that samples its stimulus. `conv_active` and the state change one edge after a start, stop or halt. `dev_rst_req` and the clearing of `data_new` also follow that one edge. A done pulse follows the start edge by the delay plus the conversion length. The driver records the edge index at which each stimulus is sampled and computes every due edge from R4 and R9. It queues those indexes. A monitor samples on the falling edge and pops the queue on each `conv_done`. It flags any pulse that arrives early, late or unqueued, and each scenario ends by checking that the queue has drained.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    localparam int DLY_W = 11;
    localparam logic [5:0] RESET_KEY = 6'b010110;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_SYNC   = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_DELAY = 2'b01,
        S_CONV  = 2'b10
    } state_t;

    function automatic logic [DLY_W-1:0] dly_clocks(input logic [2:0] code);
        logic [DLY_W-1:0] v;
        unique case (code)
            3'd0:    v = DLY_W'(0);
            3'd1:    v = DLY_W'(4);
            3'd2:    v = DLY_W'(8);
            3'd3:    v = DLY_W'(16);
            3'd4:    v = DLY_W'(32);
            3'd5:    v = DLY_W'(128);
            3'd6:    v = DLY_W'(512);
            default: v = DLY_W'(1024);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/seqc_counter.sv
module seqc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/seqc_cmd_decode.sv
module seqc_cmd_decode #(
    parameter int ADDR_W   = 8,
    parameter int CTL_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pin,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  seqc_pkg::mode_t   mode,
    input  logic              running,
    output logic              start_evt,
    output logic              stop_evt,
    output logic              restart_evt,
    output logic              sync_halt,
    output logic              reset_evt
);
    import seqc_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_CTL = ADDR_W'(CTL_ADDR);

    logic pin_q;
    logic pin_rise;
    logic bit_start;
    logic bit_stop;
    logic cmd_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= start_pin;
        end
    end

    always_comb begin
        pin_rise    = start_pin & ~pin_q;
        bit_start   = ctl_wr & ctl_wdata[1] & ~ctl_wdata[0];
        bit_stop    = ctl_wr & ctl_wdata[0] & ~ctl_wdata[1];
        cmd_mode    = (mode == MODE_FREE) || (mode == MODE_SINGLE);
        reset_evt   = ctl_wr && (ctl_wdata == {RESET_KEY, 2'b00});
        start_evt   = !reset_evt &&
                      ((cmd_mode && (bit_start || pin_rise)) ||
                       ((mode == MODE_SYNC) && pin_rise));
        stop_evt    = cmd_mode && bit_stop;
        sync_halt   = (mode == MODE_SYNC) && !start_pin && running;
        restart_evt = cfg_wr && (cfg_addr > LAST_CTL) && running;
    end

    // R12: a pin edge in a command mode is a start, same as the bit
    p_pin_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_pin) && (mode == MODE_FREE || mode == MODE_SINGLE) && !reset_evt)
        |-> start_evt);

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
    parameter int LEN_W    = 16,
    parameter int ADDR_W   = 8,
    parameter int CTL_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pin,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        mode,
    input  logic [2:0]        dly_code,
    input  logic [LEN_W-1:0]  conv_len,
    input  logic              data_rd,
    output logic              conv_active,
    output logic              conv_done,
    output logic              data_new,
    output logic              drdy_n,
    output logic              dev_rst_req
);
    import seqc_pkg::*;

    localparam int CNT_W = (LEN_W > DLY_W) ? LEN_W : DLY_W;
    localparam int CMP_W = CNT_W + 1;

    mode_t  mode_e;
    state_t state, state_n, first_st;

    logic start_evt, stop_evt, restart_evt, sync_halt, reset_evt;
    logic halt_evt;
    logic cnt_clr, cnt_en, finish;
    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] cnt_p1, dly_cmp, len_cmp;
    logic oneshot_q, stop_pend_q, done_q, new_q, rst_req_q;

    assign mode_e = mode_t'(mode);

    seqc_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .CTL_ADDR(CTL_ADDR)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pin  (start_pin),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .mode       (mode_e),
        .running    (state != S_IDLE),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .restart_evt(restart_evt),
        .sync_halt  (sync_halt),
        .reset_evt  (reset_evt)
    );

    seqc_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .en   (cnt_en),
        .cnt  (cnt)
    );

    always_comb begin
        halt_evt = sync_halt | reset_evt;
        cnt_en   = (state != S_IDLE);
        cnt_p1   = {1'b0, cnt} + 1'b1;
        dly_cmp  = CMP_W'(dly_clocks(dly_code));
        len_cmp  = CMP_W'(conv_len);
        first_st = (dly_code == 3'd0) ? S_CONV : S_DELAY;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_clr = 1'b0;
        finish  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start_evt) begin
                    state_n = first_st;
                    cnt_clr = 1'b1;
                end
            end
            S_DELAY: begin
                if (cnt_p1 >= dly_cmp) begin
                    state_n = S_CONV;
                    cnt_clr = 1'b1;
                end
            end
            S_CONV: begin
                if (cnt_p1 >= len_cmp) begin
                    finish  = 1'b1;
                    cnt_clr = 1'b1;
                    if (oneshot_q || stop_pend_q) begin
                        state_n = S_IDLE;
                    end
                end
            end
            default: begin
                state_n = S_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
        if ((state != S_IDLE) && (start_evt || restart_evt)) begin
            state_n = first_st;
            cnt_clr = 1'b1;
            finish  = 1'b0;
        end
        if (halt_evt) begin
            state_n = S_IDLE;
            cnt_clr = 1'b1;
            finish  = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // output and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oneshot_q   <= 1'b0;
            stop_pend_q <= 1'b0;
            done_q      <= 1'b0;
            new_q       <= 1'b0;
            rst_req_q   <= 1'b0;
        end else begin
            done_q    <= finish;
            rst_req_q <= reset_evt;
            if (start_evt) begin
                oneshot_q <= (mode_e == MODE_SINGLE);
            end
            if (halt_evt || state_n == S_IDLE || start_evt) begin
                stop_pend_q <= 1'b0;
            end else if (stop_evt && state != S_IDLE) begin
                stop_pend_q <= 1'b1;
            end
            if (reset_evt) begin
                new_q <= 1'b0;
            end else if (finish) begin
                new_q <= 1'b1;
            end else if (start_evt && mode_e == MODE_SINGLE) begin
                new_q <= 1'b0;
            end else if (data_rd && mode_e != MODE_SINGLE) begin
                new_q <= 1'b0;
            end
        end
    end

    assign conv_active = (state == S_CONV);
    assign conv_done   = done_q;
    assign data_new    = new_q;
    assign drdy_n      = ~new_q;
    assign dev_rst_req = rst_req_q;

    // R4: a done pulse only ever follows a counting conversion
    p_done_after_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> ($past(state) == S_CONV));

    // R13: the status bit is up whenever the done pulse is
    p_done_marks_new_r13: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> data_new);

    // R11: a low pin in pin-follow mode stops a busy sequencer at once
    p_sync_low_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_SYNC && !start_pin && state != S_IDLE) |=> (state == S_IDLE));

    // R2: reserved mode never leaves idle
    p_rsvd_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_RSVD && state == S_IDLE) |=> (state == S_IDLE));

    // R7: single-mode data stay flagged until a new start
    p_single_holds_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_SINGLE && state == S_IDLE && data_new && !start_evt && !reset_evt)
        |=> data_new);

    // R14: the reset request coincides with an idle sequencer
    p_reset_idles_r14: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_req |-> (state == S_IDLE && !data_new));

endmodule

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;

    localparam int LEN_W  = 16;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_pin = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [7:0]        ctl_wdata = '0;
    logic              cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [1:0]        mode = 2'b00;
    logic [2:0]        dly_code = 3'd0;
    logic [LEN_W-1:0]  conv_len = 16'd5;
    logic              data_rd = 1'b0;
    logic              conv_active, conv_done, data_new, drdy_n, dev_rst_req;

    int edge_n = 0;
    int checks = 0;
    int fails = 0;
    int exp_q[$];
    int mon_e;
    int e0, e1, e2, e3;
    bit finished = 1'b0;

    conv_sequencer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .CTL_ADDR(4)) dut (
        .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .mode(mode),
        .dly_code(dly_code), .conv_len(conv_len), .data_rd(data_rd),
        .conv_active(conv_active), .conv_done(conv_done), .data_new(data_new),
        .drdy_n(drdy_n), .dev_rst_req(dev_rst_req)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_dly(input int c);
        case (c)
            0: return 0;
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            5: return 128;
            6: return 512;
            default: return 1024;
        endcase
    endfunction

    task automatic expect_done(input int e);
        exp_q.push_back(e);
    endtask

    task automatic wait_edge(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] d, output int e);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        e = edge_n + 1;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic wr_cfg(input logic [ADDR_W-1:0] a, output int e);
        cfg_wr = 1'b1;
        cfg_addr = a;
        e = edge_n + 1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_addr = '0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: each done pulse must match the oldest queued due edge
    always @(negedge clk) begin
        if (rst_n && conv_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected done pulse", edge_n, -1);
            end else begin
                mon_e = exp_q.pop_front();
                chk(edge_n == mon_e, "R4 done pulse edge", edge_n, mon_e);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", edge_n, 60000);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(conv_active == 1'b0, "R1 conv_active in reset", conv_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_active == 1'b0, "R1 conv_active", conv_active, 0);
        chk(conv_done == 1'b0, "R1 conv_done", conv_done, 0);
        chk(data_new == 1'b0, "R1 data_new", data_new, 0);
        chk(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
        chk(dev_rst_req == 1'b0, "R1 dev_rst_req", dev_rst_req, 0);

        // A: free-running start, stop, data read (R3 R5 R13)
        mode = 2'b00; dly_code = 3'd0; conv_len = 16'd5;
        wr_ctl(8'h02, e0);
        expect_done(e0 + 5); expect_done(e0 + 10); expect_done(e0 + 15);
        chk(conv_active == 1'b1, "R3 active after start", conv_active, 1);
        wait_edge(e0 + 5);
        chk(data_new == 1'b1 && drdy_n == 1'b0, "R13 new data flagged", data_new, 1);
        wait_edge(e0 + 11);
        wr_ctl(8'h01, e1);
        chk(conv_active == 1'b1, "R5 still converting after stop", conv_active, 1);
        wait_edge(e0 + 16);
        chk(conv_active == 1'b0, "R5 idle after final conversion", conv_active, 0);
        chk(exp_q.size() == 0, "R5 pending done pulses", exp_q.size(), 0);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        chk(data_new == 1'b0 && drdy_n == 1'b1, "R13 read clears data_new", data_new, 0);

        // C: both bits, and command bits in pin-follow mode (R6)
        wr_ctl(8'h03, e0);
        wait_edge(e0 + 20);
        chk(conv_active == 1'b0 && exp_q.size() == 0, "R6 both bits ignored", conv_active, 0);
        mode = 2'b10;
        wr_ctl(8'h02, e0);
        wait_edge(e0 + 20);
        chk(conv_active == 1'b0, "R6 start bit ignored in pin-follow", conv_active, 0);

        // D: pin-follow mode (R11)
        conv_len = 16'd4;
        start_pin = 1'b1;
        e0 = edge_n + 1;
        expect_done(e0 + 4); expect_done(e0 + 8);
        @(negedge clk);
        chk(conv_active == 1'b1, "R11 pin rise starts", conv_active, 1);
        wait_edge(e0 + 9);
        start_pin = 1'b0;
        wait_edge(e0 + 10);
        chk(conv_active == 1'b0, "R11 low pin halts at once", conv_active, 0);
        wait_edge(e0 + 20);
        chk(exp_q.size() == 0, "R11 done pulses", exp_q.size(), 0);

        // B: single mode through every delay code (R7 R9)
        mode = 2'b01; conv_len = 16'd3;
        for (int c = 0; c < 8; c++) begin
            dly_code = 3'(c);
            wr_ctl(8'h02, e0);
            chk(data_new == 1'b0, "R7 start clears data_new", data_new, 0);
            expect_done(e0 + exp_dly(c) + 3);
            wait_edge(e0 + exp_dly(c) + 4);
            chk(conv_active == 1'b0, "R7 single conversion only", conv_active, 0);
            chk(data_new == 1'b1, "R7 data_new set", data_new, 1);
            data_rd = 1'b1;
            @(negedge clk);
            data_rd = 1'b0;
            chk(data_new == 1'b1, "R7 read does not clear", data_new, 1);
            chk(exp_q.size() == 0, "R9 delay code timing", c, exp_dly(c));
        end

        // E: restart by start bit (R8)
        mode = 2'b00; dly_code = 3'd1; conv_len = 16'd6;
        wr_ctl(8'h02, e0);
        wait_edge(e0 + 6);
        wr_ctl(8'h02, e1);
        expect_done(e1 + 10); expect_done(e1 + 16);
        wait_edge(e1 + 10);
        wr_ctl(8'h01, e2);
        wait_edge(e1 + 18);
        chk(conv_active == 1'b0 && exp_q.size() == 0, "R8 restart timing", exp_q.size(), 0);

        // F: configuration-write restart (R10)
        dly_code = 3'd0; conv_len = 16'd8;
        wr_ctl(8'h02, e0);
        expect_done(e0 + 8);
        wait_edge(e0 + 2);
        wr_cfg(8'h04, e1);
        wait_edge(e0 + 9);
        wr_cfg(8'h05, e2);
        expect_done(e2 + 8);
        wait_edge(e2 + 8);
        wr_ctl(8'h01, e3);
        expect_done(e2 + 16);
        wait_edge(e2 + 18);
        chk(conv_active == 1'b0 && exp_q.size() == 0, "R10 restart on high address", exp_q.size(), 0);
        wr_cfg(8'h09, e1);
        wait_edge(e1 + 12);
        chk(conv_active == 1'b0 && exp_q.size() == 0, "R10 idle write no effect", conv_active, 0);

        // G: pin edge in single mode (R12)
        mode = 2'b01; conv_len = 16'd3;
        start_pin = 1'b1;
        e0 = edge_n + 1;
        expect_done(e0 + 3);
        wait_edge(e0 + 5);
        chk(conv_active == 1'b0 && exp_q.size() == 0, "R12 pin edge one conversion", exp_q.size(), 0);
        start_pin = 1'b0;

        // H: reserved mode (R2)
        mode = 2'b11;
        wr_ctl(8'h02, e0);
        start_pin = 1'b1;
        wait_edge(e0 + 10);
        chk(conv_active == 1'b0 && exp_q.size() == 0, "R2 reserved mode starts nothing", conv_active, 0);
        start_pin = 1'b0;
        @(negedge clk);

        // I: reset key (R14)
        mode = 2'b00; conv_len = 16'd10;
        wr_ctl(8'h02, e0);
        wait_edge(e0 + 2);
        wr_ctl(8'h58, e1);
        chk(dev_rst_req == 1'b1, "R14 reset request pulse", dev_rst_req, 1);
        chk(conv_active == 1'b0, "R14 sequencer halted", conv_active, 0);
        chk(data_new == 1'b0, "R14 data_new cleared", data_new, 0);
        @(negedge clk);
        chk(dev_rst_req == 1'b0, "R14 pulse is one cycle", dev_rst_req, 0);
        wait_edge(e1 + 15);
        chk(exp_q.size() == 0 && conv_active == 1'b0, "R14 no done after reset", conv_active, 0);

        report();
    end

endmodule